// File: doc/BRIEF.md
# Dual-Modulus Feedback Divider Chain

This block divides a fast input clock by a programmable integer. It is meant for the feedback path of a frequency synthesizer. In prescaled mode, a divide-by-10/11 stage feeds a main counter. A swallow counter holds the divide-by-11 choice for the first part of each main cycle, so the total ratio is 10·(M+1)+A. In bypass mode the prescaler stands still, and the main counter divides the input clock directly by M+1.

The main count, the swallow count and the mode select are sampled only at the end of a full division period. A change on these inputs in the middle of a period therefore never shortens or stretches the period that is running. The divided output is a one-cycle pulse in the last input cycle of each period. The modulus-select line is brought out so that a test can observe it.

Top module: `fbd_divider`

## Requirements
- R1: With `pre_en_n` low (prescaled mode), consecutive `fp` pulses are exactly 10·(M+1)+A input cycles apart, for 1 ≤ M ≤ 511 and 0 ≤ A ≤ min(15, M+1).
- R2: With `pre_en_n` high (bypass mode), consecutive `fp` pulses are exactly M+1 input cycles apart.
- R3: In prescaled mode, `msel` is high for the first A prescaler cycles of each period (11·A input cycles), starting with the first cycle after a pulse, and is low for the rest of the period.
- R4: `fp` is high for exactly one input cycle per division period, namely the last cycle of that period.
- R5: `m_val`, `a_val` and `pre_en_n` are sampled only in the cycle in which `fp` is high. A change at any other time alters only the period that follows the next pulse.
- R6: In bypass mode `msel` stays low for the whole period and the prescaler count stays idle at zero.
- R7: While reset is applied, `fp` and `msel` are low. The first configuration is loaded right after reset without a pulse being emitted.
- R8: The boundary settings hold the same formulas. M=1 in bypass mode gives a period of 2. A=0 gives 10·(M+1). A=M+1 gives 11·(M+1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock to be divided |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| m_val | input | 9 | Main counter setting M |
| a_val | input | 4 | Swallow counter setting A |
| pre_en_n | input | 1 | Low selects prescaled mode, high selects bypass mode |
| fp | output | 1 | One-cycle pulse at the end of each division period |
| msel | output | 1 | Modulus select: high requests divide-by-11 |

## Verification
A period can end in the same cycle as a prescaler terminal count, and new settings reach the inputs close to that boundary. The reload at terminal count therefore meets a configuration change and, in prescaled mode, the prescaler restart. The bench changes the inputs one to three cycles after a pulse. It also switches between bypass and prescaled mode on consecutive boundaries and uses the smallest ratios, where the reload and the next terminal count are only two cycles apart. It judges the result by the measured spacing of the pulses and by the number of cycles `msel` is high per period. The period just after a change must still follow the old settings and the period after that must follow the new ones.

// File: rtl/fbd_pkg.sv
package fbd_pkg;

  // Default widths and base modulus of the divider chain
  parameter int unsigned FBD_M_W     = 9;
  parameter int unsigned FBD_A_W     = 4;
  parameter int unsigned FBD_PRE_MOD = 10;

  // Operating mode latched at each period boundary
  typedef enum logic {
    MODE_BYPASS   = 1'b0,
    MODE_PRESCALE = 1'b1
  } fbd_mode_e;

endpackage

// File: rtl/fbd_prescaler.sv
// Dual-modulus prescaler: counts PRE_MOD or PRE_MOD+1 input cycles per
// output terminal, chosen by msel; held idle at zero when not running.
module fbd_prescaler #(
  parameter int unsigned PRE_MOD = 10,
  localparam int unsigned PC_W   = $clog2(PRE_MOD + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            restart,
  input  logic            msel,
  output logic [PC_W-1:0] pre_cnt,
  output logic            pre_tc
);

  localparam logic [PC_W-1:0] LAST_LO = PC_W'(PRE_MOD - 1);
  localparam logic [PC_W-1:0] LAST_HI = PC_W'(PRE_MOD);

  logic [PC_W-1:0] cnt_q;
  logic [PC_W-1:0] cnt_d;
  logic            cnt_en;

  always_comb begin
    pre_tc = run && (cnt_q == (msel ? LAST_HI : LAST_LO));
    cnt_en = run || restart;
    if (restart || !run || pre_tc) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign pre_cnt = cnt_q;

endmodule

// File: rtl/fbd_main_ctr.sv
// Main down-counter: reloads at the period boundary, steps once per
// prescaler terminal (or every cycle in bypass), flags zero.
module fbd_main_ctr #(
  parameter int unsigned M_W = 9
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [M_W-1:0] load_val,
  input  logic           step,
  output logic           cnt_zero
);

  logic [M_W-1:0] cnt_q;
  logic [M_W-1:0] cnt_d;
  logic           cnt_en;

  always_comb begin
    cnt_en = load || step;
    cnt_d  = load ? load_val : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_zero = (cnt_q == '0);

endmodule

// File: rtl/fbd_swallow_ctr.sv
// Swallow counter: counts down prescaler cycles from A; while nonzero the
// prescaler is asked for its longer modulus.
module fbd_swallow_ctr #(
  parameter int unsigned A_W = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [A_W-1:0] load_val,
  input  logic           dec,
  output logic           active
);

  logic [A_W-1:0] cnt_q;
  logic [A_W-1:0] cnt_d;
  logic           cnt_en;

  always_comb begin
    active = (cnt_q != '0);
    cnt_en = load || (dec && active);
    cnt_d  = load ? load_val : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/fbd_divider.sv
// Feedback divider top: ties prescaler, main counter and swallow counter
// together and latches mode/settings only at the period boundary.
module fbd_divider
  import fbd_pkg::*;
#(
  parameter int unsigned M_W     = FBD_M_W,
  parameter int unsigned A_W     = FBD_A_W,
  parameter int unsigned PRE_MOD = FBD_PRE_MOD
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [M_W-1:0] m_val,
  input  logic [A_W-1:0] a_val,
  input  logic           pre_en_n,
  output logic           fp,
  output logic           msel
);

  localparam int unsigned PC_W = $clog2(PRE_MOD + 1);

  // Reset: asserted asynchronously, released after two clock edges
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end

  assign rst_sync_n = rst_pipe_q[1];

  // Boundary state
  logic            loaded_q;
  logic            loaded_d;
  fbd_mode_e       mode_q;
  fbd_mode_e       mode_d;
  logic            load;
  logic            main_tc;
  logic            step;
  logic            pre_tc;
  logic            mc_zero;
  logic            swallow_active;
  logic            pre_run;
  logic [A_W-1:0]  a_load;
  logic [PC_W-1:0] pre_cnt;

  always_comb begin
    pre_run  = (mode_q == MODE_PRESCALE);
    step     = pre_run ? pre_tc : 1'b1;
    main_tc  = step && mc_zero;
    load     = !loaded_q || main_tc;
    loaded_d = 1'b1;
    mode_d   = mode_q;
    if (load) begin
      mode_d = pre_en_n ? MODE_BYPASS : MODE_PRESCALE;
    end
    a_load = pre_en_n ? '0 : a_val;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      loaded_q <= 1'b0;
      mode_q   <= MODE_BYPASS;
    end else begin
      loaded_q <= loaded_d;
      if (load) begin
        mode_q <= mode_d;
      end
    end
  end

  fbd_prescaler #(
    .PRE_MOD (PRE_MOD)
  ) u_pre (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .run     (pre_run),
    .restart (load),
    .msel    (msel),
    .pre_cnt (pre_cnt),
    .pre_tc  (pre_tc)
  );

  fbd_main_ctr #(
    .M_W (M_W)
  ) u_main (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load     (load),
    .load_val (m_val),
    .step     (step),
    .cnt_zero (mc_zero)
  );

  fbd_swallow_ctr #(
    .A_W (A_W)
  ) u_swallow (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load     (load),
    .load_val (a_load),
    .dec      (pre_tc),
    .active   (swallow_active)
  );

  assign msel = pre_run && swallow_active;
  assign fp   = loaded_q && main_tc;

endmodule

// File: rtl/fbd_divider_chk.sv
module fbd_divider_chk #(
  parameter int unsigned PC_W = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            fp,
  input logic            msel,
  input logic            loaded,
  input logic            mode,
  input logic [PC_W-1:0] pre_cnt
);

  AST_FP_ONE_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
    fp |=> !fp); // R4

  AST_NO_PULSE_BEFORE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !loaded |-> (!fp && !msel)); // R7

  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (loaded && !fp) |=> $stable(mode)); // R5

  AST_MSEL_STARTS_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    (loaded && $rose(msel)) |-> ($past(fp) || !$past(loaded))); // R3

  AST_BYPASS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (loaded && !mode) |-> (pre_cnt == '0 && !msel)); // R6

endmodule

bind fbd_divider fbd_divider_chk #(
  .PC_W (PC_W)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .fp      (fp),
  .msel    (msel),
  .loaded  (loaded_q),
  .mode    (mode_q),
  .pre_cnt (pre_cnt)
);

// File: tb/fbd_divider_test.sv
module fbd_divider_test;

  typedef struct {
    int period;
    int msel_cycles;
    bit prescale;
    bit boundary;
  } exp_t;

  logic       clk;
  logic       rst_n;
  logic [8:0] m_val;
  logic [3:0] a_val;
  logic       pre_en_n;
  logic       fp;
  logic       msel;

  int   n_chk;
  int   n_bad;
  exp_t sb_q[$];

  int cur_m;
  int cur_a;
  bit cur_p;
  bit cur_b;

  fbd_divider uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .m_val    (m_val),
    .a_val    (a_val),
    .pre_en_n (pre_en_n),
    .fp       (fp),
    .msel     (msel)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int ratio(input int m, input int a, input bit bypass);
    return bypass ? (m + 1) : (10 * (m + 1) + a);
  endfunction

  task automatic apply(input int m, input int a, input bit bypass, input bit bnd);
    m_val    = 9'(m);
    a_val    = 4'(a);
    pre_en_n = bypass;
    cur_m    = m;
    cur_a    = a;
    cur_p    = bypass;
    cur_b    = bnd;
  endtask

  task automatic wait_fp();
    do @(negedge clk); while (fp !== 1'b1);
  endtask

  // Push the expectation for the period that starts after this pulse
  task automatic push_cur();
    exp_t e;
    e.period      = ratio(cur_m, cur_a, cur_p);
    e.msel_cycles = cur_p ? 0 : 11 * cur_a;
    e.prescale    = !cur_p;
    e.boundary    = cur_b;
    sb_q.push_back(e);
  endtask

  // Driver: the change lands mid-period, so it must show only one period later (R5)
  task automatic run_cfg(input int m, input int a, input bit bypass, input bit bnd);
    int dly;
    wait_fp();
    push_cur();
    dly = (ratio(cur_m, cur_a, cur_p) > 4) ? 3 : 1;
    repeat (dly) @(negedge clk);
    apply(m, a, bypass, bnd);
    wait_fp();
    push_cur();
  endtask

  // Monitor: measures pulse spacing and msel occupancy per period
  initial begin
    int  cyc;
    int  mcnt;
    bit  started;
    bit  prev_fp;
    exp_t e;
    cyc = 0; mcnt = 0; started = 1'b0; prev_fp = 1'b0;
    forever begin
      @(negedge clk);
      if (rst_n === 1'b1) begin
        cyc++;
        if (msel === 1'b1) mcnt++;
        if (fp === 1'b1) begin
          check(!prev_fp, "R4 pulse wider than one cycle", int'(prev_fp), 0);
          if (started) begin
            if (sb_q.size() == 0) begin
              check(1'b0, "R4 pulse with no expected period", cyc, 0);
            end else begin
              e = sb_q.pop_front();
              check(cyc == e.period,
                    e.prescale ? (e.boundary ? "R1 R5 R8 period" : "R1 R5 period")
                               : (e.boundary ? "R2 R5 R8 period" : "R2 R5 period"),
                    cyc, e.period);
              check(mcnt == e.msel_cycles,
                    e.prescale ? "R3 msel cycles" : "R6 msel in bypass",
                    mcnt, e.msel_cycles);
            end
          end
          started = 1'b1;
          cyc  = 0;
          mcnt = 0;
        end
        prev_fp = (fp === 1'b1);
      end
    end
  end

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    n_chk = 0;
    n_bad = 0;
    rst_n = 1'b0;
    apply(3, 2, 1'b0, 1'b0);
    // R7: outputs quiet during reset
    repeat (5) begin
      @(negedge clk);
      check(fp === 1'b0, "R7 fp in reset", int'(fp), 0);
      check(msel === 1'b0, "R7 msel in reset", int'(msel), 0);
    end
    rst_n = 1'b1;
    // R7: the first load after reset emits no pulse
    repeat (3) begin
      @(negedge clk);
      check(fp === 1'b0, "R7 no pulse on first load", int'(fp), 0);
    end

    run_cfg(1, 0, 1'b1, 1'b1);     // R8 bypass minimum ratio 2
    run_cfg(1, 0, 1'b0, 1'b1);     // R8 A=0
    run_cfg(1, 2, 1'b0, 1'b1);     // R8 A=M+1
    run_cfg(14, 15, 1'b0, 1'b1);   // R8 largest A
    run_cfg(1, 0, 1'b1, 1'b1);     // mode switch back to bypass
    run_cfg(511, 0, 1'b1, 1'b1);   // R2 largest bypass
    run_cfg(511, 15, 1'b0, 1'b1);  // R1 largest ratio
    run_cfg(5, 3, 1'b0, 1'b0);
    run_cfg(5, 3, 1'b1, 1'b0);     // same M and A, bypass ignores A (R6)
    for (int i = 0; i < 20; i++) begin
      int m;
      int amax;
      int a;
      bit bp;
      m    = 1 + int'($urandom % 80);
      amax = (m + 1 < 15) ? m + 1 : 15;
      a    = int'($urandom % (amax + 1));
      bp   = 1'($urandom % 2);
      run_cfg(m, a, bp, 1'b0);
    end
    wait_fp();
    @(negedge clk);
    @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule